// File: doc/BRIEF.md
# AHB register-file bridge

This block is an AHB-Lite slave that fronts a small register file. A bus master reaches four internal 32-bit registers with fixed access types, and a separate external window that a neighbouring memory or register bank serves through a request/acknowledge handshake. Every bus signal is a flat port. The address phase is decoded and registered while the slave is ready. Write data is taken in the following data phase. The ready output is held low while an external acknowledge is still outstanding.

Two build-time options select the error policy. One returns ERROR for addresses that hit nothing. The other returns ERROR for reads of a write-only register and for writes of a read-only register. With an option switched off, the matching accesses complete with OKAY: such reads return zero and such writes are dropped. Either way, a rejected write never alters a register.

Top module: `ahb_regfile_bridge`

## Requirements
- R1: Reset is synchronous and active high. After reset, `hready_o` is 1 and `hresp_o` is 0 (OKAY). CTRL and CMD read 0, SCRATCH holds `SCRATCH_RST` (default 0x0000FFFF), and ID holds `ID_WORD` (default 0x5A1E0C01).
- R2: Addresses are byte addresses, and only word accesses are mapped: `hsize_i` = 3'b010 with `haddr_i[1:0]` = 0. The map is: 0x000 CTRL (read/write, drives `ctrl_o`), 0x004 ID (read-only), 0x008 SCRATCH (read/write), 0x00C CMD (write-only, drives `cmd_o`), and the external window from `EXT_BASE` (0x100) to `EXT_BASE+EXT_BYTES-1` (0x1FF). Every other address or size is unmapped.
- R3: An access starts only when `hsel_i` is 1 and `htrans_i` is NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00) and BUSY (2'b01) leave every register unchanged and cause no stall.
- R4: Internal accesses take no wait states. Read data appears with `hready_o`=1 in the data phase. Write data is sampled in the data phase, not in the address phase. A read issued in the data phase of a write to the same register returns the new value.
- R5: An ERROR response lasts two cycles. In the first cycle `hresp_o`=1 and `hready_o`=0. In the second cycle `hresp_o`=1 and `hready_o`=1.
- R6: With `ERR_BAD_ADDR`=1, any unmapped access, including a misaligned or non-word one, returns ERROR.
- R7: With `ERR_BAD_DIR`=1, a read of CMD or a write of ID returns ERROR.
- R8: An access that returns ERROR modifies no register.
- R9: With both options 0, an unmapped read or a read of CMD returns 0 with OKAY. An unmapped write or a write of ID completes with OKAY and changes nothing.
- R10: An external access raises `ext_req_o` for exactly one cycle, one clock after the address is captured. With the pulse it presents the byte offset inside the window, the write flag and the data-phase write data. `hready_o` then stays low until `ext_ack_i` is seen, so the data phase stalls for 2 + (cycles from the request to the acknowledge) cycles. A read returns `ext_rdata_i` as sampled with the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hsel_i | input | 1 | Slave select |
| htrans_i | input | 2 | Transfer type |
| hwrite_i | input | 1 | 1 = write, 0 = read |
| hsize_i | input | 3 | Transfer size |
| haddr_i | input | ADDR_W | Byte address |
| hwdata_i | input | DATA_W | Write data (data phase) |
| hready_o | output | 1 | Transfer done; low stretches the data phase |
| hrdata_o | output | DATA_W | Read data |
| hresp_o | output | 1 | 0 OKAY, 1 ERROR |
| ext_req_o | output | 1 | External window request strobe |
| ext_wr_o | output | 1 | External access is a write |
| ext_addr_o | output | EXT_AW | Byte offset inside the external window |
| ext_wdata_o | output | DATA_W | External write data |
| ext_ack_i | input | 1 | One-cycle external acknowledge |
| ext_rdata_i | input | DATA_W | External read data, valid with acknowledge |
| ctrl_o | output | DATA_W | CTRL register contents |
| cmd_o | output | DATA_W | CMD register contents |

## Verification
The case hardest to reach from the ports is a read whose address phase overlaps the data phase of a write to the same register. The read data must then come from the bus, because the register still holds the old value. The bench drives this with a dedicated pipelined sequence that places the read address in the write's data-phase cycle. External stalls of several lengths come from a bench responder whose acknowledge delay is set before each access, and the measured stall count is checked against 2 plus that delay. The relaxed error policy runs on a second instance that shares the bus.

// File: rtl/ahbrf_pkg.sv
package ahbrf_pkg;

  localparam int NUM_REGS  = 4;
  localparam int REG_IDX_W = $clog2(NUM_REGS);

  typedef enum logic [1:0] {ACC_RW, ACC_RO, ACC_WO} acc_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ERR1, S_ERR2, S_EXT_ISSUE, S_EXT_WAIT
  } state_e;

  typedef struct packed {
    logic                 hit_reg;
    logic                 hit_ext;
    logic                 readable;
    logic                 writable;
    logic                 reject;
    logic [REG_IDX_W-1:0] idx;
  } dec_t;

  // access type per internal register index
  function automatic acc_e reg_access(input int idx);
    case (idx)
      1:       return ACC_RO;
      3:       return ACC_WO;
      default: return ACC_RW;
    endcase
  endfunction

endpackage

// File: rtl/ahbrf_decode.sv
module ahbrf_decode
  import ahbrf_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int EXT_BASE     = 'h100,
  parameter int EXT_BYTES    = 256,
  parameter bit ERR_BAD_ADDR = 1'b1,
  parameter bit ERR_BAD_DIR  = 1'b1,
  localparam int EXT_AW      = $clog2(EXT_BYTES)
) (
  input  logic [ADDR_W-1:0] haddr,
  input  logic [2:0]        hsize,
  input  logic              hwrite,
  output dec_t              dec,
  output logic [EXT_AW-1:0] ext_off
);

  localparam logic [ADDR_W-1:0] EXT_LO   = ADDR_W'(EXT_BASE);
  localparam logic [ADDR_W-1:0] EXT_LAST = ADDR_W'(EXT_BASE + EXT_BYTES - 1);
  localparam logic [ADDR_W-1:0] REG_END  = ADDR_W'(NUM_REGS * 4);

  logic word_ok;
  acc_e kind;

  assign word_ok = (hsize == 3'b010) && (haddr[1:0] == 2'b00);
  assign kind    = reg_access(int'(haddr[2 +: REG_IDX_W]));

  always_comb begin
    dec          = '0;
    dec.idx      = haddr[2 +: REG_IDX_W];
    dec.hit_reg  = word_ok && (haddr < REG_END);
    dec.hit_ext  = word_ok && (haddr >= EXT_LO) && (haddr <= EXT_LAST);
    dec.readable = (kind != ACC_WO);
    dec.writable = (kind != ACC_RO);
    dec.reject   = (ERR_BAD_ADDR && !dec.hit_reg && !dec.hit_ext) ||
                   (ERR_BAD_DIR && dec.hit_reg &&
                    (hwrite ? !dec.writable : !dec.readable));
  end

  assign ext_off = EXT_AW'(haddr - EXT_LO);

endmodule

// File: rtl/ahbrf_regs.sv
module ahbrf_regs
  import ahbrf_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter logic [DATA_W-1:0] ID_WORD     = 32'h5A1E_0C01,
  parameter logic [DATA_W-1:0] SCRATCH_RST = 32'h0000_FFFF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [REG_IDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [REG_IDX_W-1:0] rd_idx,
  output logic [DATA_W-1:0]    rd_data,
  output logic [DATA_W-1:0]    ctrl_q,
  output logic [DATA_W-1:0]    cmd_q
);

  logic [DATA_W-1:0] q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam acc_e KIND = reg_access(g);
    localparam logic [DATA_W-1:0] RST_VAL = (g == 2) ? SCRATCH_RST : '0;
    if (KIND == ACC_RO) begin : g_const
      assign q[g] = ID_WORD;
    end else begin : g_flop
      always_ff @(posedge clk) begin
        if (rst)
          q[g] <= RST_VAL;
        else if (wr_en && (wr_idx == REG_IDX_W'(g)))
          q[g] <= wr_data;
      end
    end
  end

  assign rd_data = q[rd_idx];
  assign ctrl_q  = q[0];
  assign cmd_q   = q[3];

endmodule

// File: rtl/ahbrf_ctrl.sv
module ahbrf_ctrl
  import ahbrf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXT_AW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hsel,
  input  logic [1:0]           htrans,
  input  logic                 hwrite,
  input  logic [DATA_W-1:0]    hwdata,
  input  dec_t                 dec,
  input  logic [EXT_AW-1:0]    ext_off,
  input  logic [DATA_W-1:0]    reg_rdata,
  output logic                 wr_en,
  output logic [REG_IDX_W-1:0] wr_idx,
  output logic                 hready,
  output logic                 hresp,
  output logic [DATA_W-1:0]    hrdata,
  output logic                 ext_req,
  output logic                 ext_wr,
  output logic [EXT_AW-1:0]    ext_addr,
  output logic [DATA_W-1:0]    ext_wdata,
  input  logic                 ext_ack,
  input  logic [DATA_W-1:0]    ext_rdata
);

  state_e               state;
  logic                 acc_go;
  logic                 dph_wr;
  logic [REG_IDX_W-1:0] dph_idx;
  logic [DATA_W-1:0]    rd_fwd;

  assign acc_go = hsel && htrans[1] && hready;
  // a read overlapping the data phase of a write to the same slot sees the bus data
  assign rd_fwd = (dph_wr && (dph_idx == dec.idx)) ? hwdata : reg_rdata;
  assign wr_en  = dph_wr;
  assign wr_idx = dph_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      hready    <= 1'b1;
      hresp     <= 1'b0;
      hrdata    <= '0;
      dph_wr    <= 1'b0;
      dph_idx   <= '0;
      ext_req   <= 1'b0;
      ext_wr    <= 1'b0;
      ext_addr  <= '0;
      ext_wdata <= '0;
    end else begin
      dph_wr  <= 1'b0;
      ext_req <= 1'b0;
      if (acc_go) begin
        if (dec.reject) begin
          state  <= S_ERR1;
          hready <= 1'b0;
          hresp  <= 1'b1;
        end else if (dec.hit_ext) begin
          state    <= S_EXT_ISSUE;
          hready   <= 1'b0;
          hresp    <= 1'b0;
          ext_wr   <= hwrite;
          ext_addr <= ext_off;
        end else begin
          state   <= S_IDLE;
          hresp   <= 1'b0;
          dph_wr  <= hwrite && dec.hit_reg && dec.writable;
          dph_idx <= dec.idx;
          hrdata  <= (!hwrite && dec.hit_reg && dec.readable) ? rd_fwd : '0;
        end
      end else begin
        case (state)
          S_ERR1: begin
            state  <= S_ERR2;
            hready <= 1'b1;
          end
          S_ERR2: begin
            state <= S_IDLE;
            hresp <= 1'b0;
          end
          S_EXT_ISSUE: begin
            ext_req   <= 1'b1;
            ext_wdata <= hwdata;
            state     <= S_EXT_WAIT;
          end
          S_EXT_WAIT: begin
            if (ext_ack) begin
              hready <= 1'b1;
              if (!ext_wr) hrdata <= ext_rdata;
              state <= S_IDLE;
            end
          end
          default: hresp <= 1'b0;
        endcase
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (hready && !hresp));

  assert_err_second_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    (hresp && !hready) |=> (hresp && hready));

  assert_err_first_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(hresp) |-> !hready);

  assert_ext_req_stalls_R10: assert property (@(posedge clk) disable iff (rst)
    ext_req |-> !hready);

  assert_ext_req_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    ext_req |=> !ext_req);

  assert_ext_ack_done_R10: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXT_WAIT && ext_ack) |=> (hready && !hresp));

endmodule

// File: rtl/ahb_regfile_bridge.sv
module ahb_regfile_bridge
  import ahbrf_pkg::*;
#(
  parameter int                ADDR_W       = 12,
  parameter int                DATA_W       = 32,
  parameter int                EXT_BASE     = 'h100,
  parameter int                EXT_BYTES    = 256,
  parameter bit                ERR_BAD_ADDR = 1'b1,
  parameter bit                ERR_BAD_DIR  = 1'b1,
  parameter logic [DATA_W-1:0] ID_WORD      = 32'h5A1E_0C01,
  parameter logic [DATA_W-1:0] SCRATCH_RST  = 32'h0000_FFFF,
  localparam int               EXT_AW       = $clog2(EXT_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsel_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [2:0]        hsize_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [DATA_W-1:0] hwdata_i,
  output logic              hready_o,
  output logic [DATA_W-1:0] hrdata_o,
  output logic              hresp_o,
  output logic              ext_req_o,
  output logic              ext_wr_o,
  output logic [EXT_AW-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  input  logic              ext_ack_i,
  input  logic [DATA_W-1:0] ext_rdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] cmd_o
);

  dec_t                 dec;
  logic [EXT_AW-1:0]    ext_off;
  logic [DATA_W-1:0]    reg_rdata;
  logic                 wr_en;
  logic [REG_IDX_W-1:0] wr_idx;

  ahbrf_decode #(
    .ADDR_W(ADDR_W), .EXT_BASE(EXT_BASE), .EXT_BYTES(EXT_BYTES),
    .ERR_BAD_ADDR(ERR_BAD_ADDR), .ERR_BAD_DIR(ERR_BAD_DIR)
  ) decode_i (
    .haddr(haddr_i), .hsize(hsize_i), .hwrite(hwrite_i),
    .dec(dec), .ext_off(ext_off)
  );

  ahbrf_regs #(
    .DATA_W(DATA_W), .ID_WORD(ID_WORD), .SCRATCH_RST(SCRATCH_RST)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(hwdata_i),
    .rd_idx(dec.idx), .rd_data(reg_rdata), .ctrl_q(ctrl_o), .cmd_q(cmd_o)
  );

  ahbrf_ctrl #(.DATA_W(DATA_W), .EXT_AW(EXT_AW)) ctrl_i (
    .clk(clk), .rst(rst), .hsel(hsel_i), .htrans(htrans_i), .hwrite(hwrite_i),
    .hwdata(hwdata_i), .dec(dec), .ext_off(ext_off), .reg_rdata(reg_rdata),
    .wr_en(wr_en), .wr_idx(wr_idx), .hready(hready_o), .hresp(hresp_o),
    .hrdata(hrdata_o), .ext_req(ext_req_o), .ext_wr(ext_wr_o),
    .ext_addr(ext_addr_o), .ext_wdata(ext_wdata_o), .ext_ack(ext_ack_i),
    .ext_rdata(ext_rdata_i)
  );

  assert_reject_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    (hresp_o && !hready_o) |=> ($stable(ctrl_o) && $stable(cmd_o)));

  assert_idle_no_stall_R3: assert property (@(posedge clk) disable iff (rst)
    (hready_o && !(hsel_i && htrans_i[1])) |=> hready_o);

endmodule

// File: tb/ahb_regfile_bridge_tb_top.sv
`timescale 1ns/1ps
module ahb_regfile_bridge_tb_top;

  localparam logic [31:0] ID    = 32'h5A1E_0C01;
  localparam logic [1:0]  T_IDL = 2'b00, T_BSY = 2'b01, T_NS = 2'b10, T_SQ = 2'b11;
  localparam logic [2:0]  SZ_W  = 3'b010, SZ_B = 3'b000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        hsel = 1'b0, hwrite = 1'b0, use_lax = 1'b0, ext_ack = 1'b0;
  logic [1:0]  htrans = T_IDL;
  logic [2:0]  hsize = SZ_W;
  logic [11:0] haddr = '0;
  logic [31:0] hwdata = '0, ext_rdata = '0;

  logic        r_m, p_m, q_m, w_m, r_l, p_l, q_l, w_l;
  logic [31:0] d_m, d_l, wd_m, wd_l, ctrl_m, cmd_m, ctrl_l, cmd_l;
  logic [7:0]  a_m, a_l;

  ahb_regfile_bridge dut_i (
    .clk(clk), .rst(rst), .hsel_i(hsel && !use_lax), .htrans_i(htrans),
    .hwrite_i(hwrite), .hsize_i(hsize), .haddr_i(haddr), .hwdata_i(hwdata),
    .hready_o(r_m), .hrdata_o(d_m), .hresp_o(p_m), .ext_req_o(q_m),
    .ext_wr_o(w_m), .ext_addr_o(a_m), .ext_wdata_o(wd_m), .ext_ack_i(ext_ack),
    .ext_rdata_i(ext_rdata), .ctrl_o(ctrl_m), .cmd_o(cmd_m));

  ahb_regfile_bridge #(.ERR_BAD_ADDR(1'b0), .ERR_BAD_DIR(1'b0)) dut_lax_i (
    .clk(clk), .rst(rst), .hsel_i(hsel && use_lax), .htrans_i(htrans),
    .hwrite_i(hwrite), .hsize_i(hsize), .haddr_i(haddr), .hwdata_i(hwdata),
    .hready_o(r_l), .hrdata_o(d_l), .hresp_o(p_l), .ext_req_o(q_l),
    .ext_wr_o(w_l), .ext_addr_o(a_l), .ext_wdata_o(wd_l), .ext_ack_i(ext_ack),
    .ext_rdata_i(ext_rdata), .ctrl_o(ctrl_l), .cmd_o(cmd_l));

  wire        c_rdy = use_lax ? r_l : r_m;
  wire        c_rsp = use_lax ? p_l : p_m;
  wire [31:0] c_dat = use_lax ? d_l : d_m;
  wire        c_req = use_lax ? q_l : q_m;
  wire        c_wr  = use_lax ? w_l : w_m;
  wire [7:0]  c_adr = use_lax ? a_l : a_m;
  wire [31:0] c_wd  = use_lax ? wd_l : wd_m;

  int n_chk = 0, n_err = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural external responder: word memory plus programmable ack delay
  logic [31:0] ext_mem [64];
  int          ext_delay = 0, ext_cnt = 0;
  bit          ext_pend = 0;
  logic [7:0]  last_addr = '0;
  logic        last_wr = 1'b0;
  logic [31:0] last_wd = '0;
  initial for (int i = 0; i < 64; i++) ext_mem[i] = '0;

  always @(negedge clk) begin
    ext_ack = 1'b0;
    if (!rst && c_req) begin
      last_addr = c_adr; last_wr = c_wr; last_wd = c_wd;
      if (c_wr) ext_mem[c_adr[7:2]] = c_wd;
      ext_pend = 1; ext_cnt = ext_delay;
    end
    if (ext_pend) begin
      if (ext_cnt == 0) begin
        ext_ack = 1'b1; ext_rdata = ext_mem[last_addr[7:2]]; ext_pend = 0;
      end else ext_cnt--;
    end
  end

  // per-clock protocol monitor on the selected instance
  logic prev_rsp = 1'b0, prev_rdy = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      if (c_rsp && c_rdy) chk("R5 error second cycle follows stalled error", {31'b0, prev_rsp && !prev_rdy}, 32'd1);
      if (c_req) chk("R10 request only while stalled", {31'b0, c_rdy}, 32'd0);
    end
    prev_rsp = c_rsp; prev_rdy = c_rdy;
  end

  task automatic xfer(input bit lax, input logic [1:0] tr, input bit wr, input logic [11:0] a,
                      input logic [2:0] sz, input logic [31:0] wd,
                      output logic [31:0] rd, output logic rsp, output int st, output logic rsp0);
    @(negedge clk);
    use_lax = lax; hsel = 1'b1; htrans = tr; hwrite = wr; haddr = a; hsize = sz; hwdata = ~wd;
    @(negedge clk);
    hsel = 1'b0; htrans = T_IDL; hwdata = wd; st = 0; rsp0 = c_rsp;
    while (!c_rdy) begin st++; @(negedge clk); end
    rd = c_dat; rsp = c_rsp;
    @(negedge clk);
  endtask

  task automatic do_acc(input string tag, input bit lax, input logic [1:0] tr, input bit wr,
                        input logic [11:0] a, input logic [2:0] sz, input logic [31:0] d,
                        input logic exp_rsp, input int exp_st);
    logic [31:0] rd; logic rsp, rsp0; int st;
    xfer(lax, tr, wr, a, sz, d, rd, rsp, st, rsp0);
    chk({tag, " response"}, {31'b0, rsp}, {31'b0, exp_rsp});
    chk({tag, " stall cycles"}, st, exp_st);
    if (exp_rsp) chk({tag, " first error cycle"}, {31'b0, rsp0}, 32'd1);
    else if (!wr) chk({tag, " read data"}, rd, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", {31'b0, r_m}, 32'd1);
    chk("R1 okay after reset", {31'b0, p_m}, 32'd0);
    chk("R1 ctrl reset", ctrl_m, 32'd0);
    chk("R1 cmd reset", cmd_m, 32'd0);
    chk("R1 relaxed ready after reset", {31'b0, r_l}, 32'd1);

    do_acc("R2 ID read", 0, T_NS, 0, 12'h004, SZ_W, ID, 1'b0, 0);
    do_acc("R1 SCRATCH reset read", 0, T_NS, 0, 12'h008, SZ_W, 32'h0000_FFFF, 1'b0, 0);
    do_acc("R4 CTRL write", 0, T_NS, 1, 12'h000, SZ_W, 32'h1234_5678, 1'b0, 0);
    chk("R4 ctrl_o after write", ctrl_m, 32'h1234_5678);
    do_acc("R4 CTRL readback SEQ", 0, T_SQ, 0, 12'h000, SZ_W, 32'h1234_5678, 1'b0, 0);
    do_acc("R2 CMD write", 0, T_NS, 1, 12'h00C, SZ_W, 32'h0000_CAFE, 1'b0, 0);
    chk("R2 cmd_o after write", cmd_m, 32'h0000_CAFE);

    do_acc("R3 IDLE write", 0, T_IDL, 1, 12'h000, SZ_W, 32'hDEAD_0001, 1'b0, 0);
    do_acc("R3 BUSY write", 0, T_BSY, 1, 12'h000, SZ_W, 32'hDEAD_0002, 1'b0, 0);
    chk("R3 ctrl_o unchanged by IDLE/BUSY", ctrl_m, 32'h1234_5678);

    do_acc("R6 unmapped read", 0, T_NS, 0, 12'h020, SZ_W, 32'h0, 1'b1, 1);
    do_acc("R6 misaligned read", 0, T_NS, 0, 12'h002, SZ_W, 32'h0, 1'b1, 1);
    do_acc("R6 byte-size read", 0, T_NS, 0, 12'h008, SZ_B, 32'h0, 1'b1, 1);
    do_acc("R7 write read-only ID", 0, T_NS, 1, 12'h004, SZ_W, 32'h0000_0001, 1'b1, 1);
    do_acc("R8 ID intact", 0, T_NS, 0, 12'h004, SZ_W, ID, 1'b0, 0);
    do_acc("R7 read write-only CMD", 0, T_NS, 0, 12'h00C, SZ_W, 32'h0, 1'b1, 1);
    do_acc("R8 misaligned CTRL write", 0, T_NS, 1, 12'h001, SZ_W, 32'hBAD0_0BAD, 1'b1, 1);
    do_acc("R8 unmapped write", 0, T_NS, 1, 12'h040, SZ_W, 32'hBAD1_1BAD, 1'b1, 1);
    chk("R8 ctrl_o unchanged after rejects", ctrl_m, 32'h1234_5678);
    chk("R8 cmd_o unchanged after rejects", cmd_m, 32'h0000_CAFE);

    do_acc("R9 relaxed unmapped read", 1, T_NS, 0, 12'h020, SZ_W, 32'h0, 1'b0, 0);
    do_acc("R9 relaxed CMD write", 1, T_NS, 1, 12'h00C, SZ_W, 32'h0000_0077, 1'b0, 0);
    chk("R9 relaxed cmd_o", cmd_l, 32'h0000_0077);
    do_acc("R9 relaxed CMD read gives zero", 1, T_NS, 0, 12'h00C, SZ_W, 32'h0, 1'b0, 0);
    do_acc("R9 relaxed ID write", 1, T_NS, 1, 12'h004, SZ_W, 32'h0000_0001, 1'b0, 0);
    do_acc("R9 relaxed ID intact", 1, T_NS, 0, 12'h004, SZ_W, ID, 1'b0, 0);
    do_acc("R9 relaxed unmapped write", 1, T_NS, 1, 12'h030, SZ_W, 32'hFFFF_FFFF, 1'b0, 0);
    chk("R9 relaxed ctrl_o unchanged", ctrl_l, 32'h0);

    ext_delay = 0;
    do_acc("R10 ext write delay 0", 0, T_NS, 1, 12'h108, SZ_W, 32'h0000_00A1, 1'b0, 2);
    chk("R10 ext offset", {24'b0, last_addr}, 32'h08);
    chk("R10 ext write flag", {31'b0, last_wr}, 32'd1);
    chk("R10 ext write data", last_wd, 32'h0000_00A1);
    ext_delay = 3;
    do_acc("R10 ext read delay 3", 0, T_SQ, 0, 12'h108, SZ_W, 32'h0000_00A1, 1'b0, 5);
    chk("R10 ext read flag", {31'b0, last_wr}, 32'd0);
    ext_delay = 7;
    do_acc("R10 ext write last word delay 7", 0, T_NS, 1, 12'h1FC, SZ_W, 32'h0000_00B2, 1'b0, 9);
    ext_delay = 1;
    do_acc("R10 ext read last word delay 1", 0, T_NS, 0, 12'h1FC, SZ_W, 32'h0000_00B2, 1'b0, 3);
    chk("R10 ext last offset", {24'b0, last_addr}, 32'hFC);

    // R4: read placed in the data phase of a write to the same register
    @(negedge clk);
    use_lax = 1'b0; hsel = 1'b1; htrans = T_NS; hwrite = 1'b1; haddr = 12'h008; hsize = SZ_W;
    hwdata = 32'h0;
    @(negedge clk);
    hwdata = 32'h0BAD_F00D; hwrite = 1'b0; htrans = T_NS; haddr = 12'h008;
    @(negedge clk);
    hsel = 1'b0; htrans = T_IDL;
    chk("R4 read-after-write ready", {31'b0, c_rdy}, 32'd1);
    chk("R4 read-after-write data", c_dat, 32'h0BAD_F00D);
    @(negedge clk);
    do_acc("R4 SCRATCH holds written value", 0, T_NS, 0, 12'h008, SZ_W, 32'h0BAD_F00D, 1'b0, 0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule